// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences the power-down state of a small microcontroller core. The core decodes its halt instruction and raises a one-cycle sleep strobe. The controller then stops the core clock and the main oscillator, records the entry in two active-low status bits and clears the watchdog. While the core is halted, a qualified interrupt request or a watchdog time-out restarts the oscillator. After a fixed settling count the controller ungates the core clock.

An interrupt source wakes the core only when its own enable is set and it is built to run without the core clock. The global interrupt enable never blocks a wake-up. It only decides what happens after the wake-up. With it clear, the core simply continues. With it set, the core still executes the instruction it had already fetched and then jumps to the interrupt vector. The controller reports this choice with a one-cycle flag beside the wake-release pulse.

If an enabled request is already pending when the strobe arrives, the halt instruction still completes and updates the status bits, but the clocks are never stopped. An external reset input forces a full device reset from any state and leaves the status bits alone, so software can tell afterwards why the core restarted.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset, core_clk_en=1, osc_en=1, pd_n=1, to_n=1, and wdt_clr, wake_done, vec_next and dev_rst are all 0.
- R2: If sleep_req is sampled in the running state and no source has flag and enable both set, then on the next cycle core_clk_en=0, osc_en=0, pd_n=0 and to_n=1, and wdt_clr is high for exactly that one cycle.
- R3: While asleep, an interrupt source wakes the core only if irq_flag[i], irq_en[i] and bit i of CAP_MASK are all 1. The value of gie does not matter. Any other combination leaves core_clk_en and osc_en at 0.
- R4: The first clock edge that samples a qualifying request is edge 0. After edge SYNC_STAGES, osc_en is 1. After edge SYNC_STAGES+OSC_READY, core_clk_en is 1.
- R5: A wdt_timeout sampled while asleep sets osc_en=1 and clears to_n on the next cycle. core_clk_en returns OSC_READY cycles after that.
- R6: In the cycle core_clk_en returns after a wake, wake_done and wdt_clr are high for one cycle, and vec_next equals gie. pd_n stays 0.
- R7: If any source (capable or not) has flag and enable set when sleep_req is sampled, then on the next cycle core_clk_en=1 and osc_en=1. In that same cycle pd_n=0, to_n=1, wdt_clr=1, wake_done=1 and vec_next=gie.
- R8: ext_reset sampled high in any state gives, on the next cycle, dev_rst=1, core_clk_en=1, osc_en=1, wake_done=0 and wdt_clr=0. pd_n and to_n keep their values.
- R9: sleep_req while asleep has no effect: the clocks stay off, wdt_clr stays 0, and pd_n and to_n do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | One-cycle strobe from the decoded halt instruction |
| irq_flag | input | N | Per-source interrupt request flags |
| irq_en | input | N | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| ext_reset | input | 1 | External reset request |
| core_clk_en | output | 1 | Core clock-gate enable |
| osc_en | output | 1 | Main oscillator enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| pd_n | output | 1 | Power-down status, 0 after a halt instruction |
| to_n | output | 1 | Time-out status, 0 after a watchdog wake |
| wake_done | output | 1 | One-cycle marker that the core resumes |
| vec_next | output | 1 | With wake_done: run the fetched instruction, then vector |
| dev_rst | output | 1 | Full device reset request |

## Verification
The flag and enable vectors are drawn at random after each sleep entry. This mixes requests that qualify, requests from the one source that cannot run without the clock, and requests with the enable missing. Together they separate correct wake qualification from a wake driven by flags alone or by the global enable. Watchdog wakes are kept apart from interrupt wakes by their shorter latency and by the time-out bit. Pending requests at the strobe, including one from a source that cannot wake the core, check the immediate-wake path. Directed cases cover external reset while asleep and a repeated strobe while asleep.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } slp_state_e;

    typedef struct packed {
        logic clk_en;
        logic osc_en;
        logic wdt_clr;
        logic wake_done;
        logic vec_next;
        logic dev_rst;
    } core_ctl_t;

    localparam core_ctl_t CTL_IDLE = '{clk_en: 1'b1, osc_en: 1'b1, default: 1'b0};

    function automatic logic is_halted(slp_state_e s);
        return s != ST_RUN;
    endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
    parameter int             N           = 8,
    parameter logic [N-1:0]   CAP_MASK    = '1,
    parameter int             SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_flag,
    input  logic [N-1:0] irq_en,
    output logic         armed_any,
    output logic         wake_sync
);
    logic [N-1:0]           armed_vec;
    logic                   wake_raw;
    logic [SYNC_STAGES-1:0] chain;

    assign armed_vec = irq_flag & irq_en;
    assign armed_any = |armed_vec;
    assign wake_raw  = |(armed_vec & CAP_MASK);

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= wake_raw;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign wake_sync = chain[SYNC_STAGES-1];

    // R3
    sync_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chain[0]) |-> $past(wake_raw));
endmodule

// File: rtl/slp_ready_timer.sv
module slp_ready_timer #(
    parameter int OSC_READY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ready
);
    localparam int CW = $clog2(OSC_READY + 1);
    localparam logic [CW-1:0] LAST = CW'(OSC_READY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign ready = run && (cnt == LAST);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/slp_status.sv
module slp_status (
    input  logic clk,
    input  logic rst,
    input  logic enter_sleep,
    input  logic wdt_wake,
    output logic pd_n,
    output logic to_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_n <= 1'b1;
            to_n <= 1'b1;
        end else if (enter_sleep) begin
            pd_n <= 1'b0;
            to_n <= 1'b1;
        end else if (wdt_wake) begin
            to_n <= 1'b0;
        end
    end

    // R9
    pd_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_n) |-> $past(enter_sleep));

    // R5
    to_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(to_n) |-> $past(wdt_wake));
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int           N           = 8,
    parameter logic [N-1:0] CAP_MASK    = '1,
    parameter int           SYNC_STAGES = 2,
    parameter int           OSC_READY   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep_req,
    input  logic [N-1:0] irq_flag,
    input  logic [N-1:0] irq_en,
    input  logic         gie,
    input  logic         wdt_timeout,
    input  logic         ext_reset,
    output logic         core_clk_en,
    output logic         osc_en,
    output logic         wdt_clr,
    output logic         pd_n,
    output logic         to_n,
    output logic         wake_done,
    output logic         vec_next,
    output logic         dev_rst
);
    slp_state_e state;
    core_ctl_t  ctl;
    logic       armed_any, wake_sync, ready;
    logic       enter_sleep, wdt_wake;

    slp_wake_qual #(.N(N), .CAP_MASK(CAP_MASK), .SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk(clk), .rst(rst), .irq_flag(irq_flag), .irq_en(irq_en),
        .armed_any(armed_any), .wake_sync(wake_sync)
    );

    slp_ready_timer #(.OSC_READY(OSC_READY)) u_timer (
        .clk(clk), .rst(rst), .run(state == ST_WAKE), .ready(ready)
    );

    assign enter_sleep = (state == ST_RUN) && sleep_req && !ext_reset;
    assign wdt_wake    = (state == ST_SLEEP) && wdt_timeout && !ext_reset;

    slp_status u_status (
        .clk(clk), .rst(rst), .enter_sleep(enter_sleep), .wdt_wake(wdt_wake),
        .pd_n(pd_n), .to_n(to_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            ctl   <= CTL_IDLE;
        end else if (ext_reset) begin
            state       <= ST_RUN;
            ctl         <= CTL_IDLE;
            ctl.dev_rst <= 1'b1;
        end else begin
            ctl.wdt_clr   <= 1'b0;
            ctl.wake_done <= 1'b0;
            ctl.vec_next  <= 1'b0;
            ctl.dev_rst   <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_req) begin
                        ctl.wdt_clr <= 1'b1;
                        if (armed_any) begin
                            ctl.wake_done <= 1'b1;
                            ctl.vec_next  <= gie;
                        end else begin
                            state      <= ST_SLEEP;
                            ctl.clk_en <= 1'b0;
                            ctl.osc_en <= 1'b0;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (wdt_timeout || wake_sync) begin
                        state      <= ST_WAKE;
                        ctl.osc_en <= 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (ready) begin
                        state         <= ST_RUN;
                        ctl.clk_en    <= 1'b1;
                        ctl.wdt_clr   <= 1'b1;
                        ctl.wake_done <= 1'b1;
                        ctl.vec_next  <= gie;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign core_clk_en = ctl.clk_en;
    assign osc_en      = ctl.osc_en;
    assign wdt_clr     = ctl.wdt_clr;
    assign wake_done   = ctl.wake_done;
    assign vec_next    = ctl.vec_next;
    assign dev_rst     = ctl.dev_rst;

    // R2
    asleep_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP) |-> (!core_clk_en && !osc_en));

    // R4
    clk_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        core_clk_en |-> osc_en);

    // R6
    vec_with_release_chk: assert property (@(posedge clk) disable iff (rst)
        vec_next |-> wake_done);

    // R6
    release_clears_wdt_chk: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> (wdt_clr && core_clk_en));

    // R8
    ext_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ext_reset) |-> (core_clk_en && dev_rst && !wake_done && !wdt_clr));

    // R9
    halted_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (is_halted(state) && $past(is_halted(state))) |-> !core_clk_en);
endmodule

// File: tb/slp_wake_ctrl_test.sv
module slp_wake_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int SYNC = 2;
    localparam int RDY  = 5;
    localparam logic [N-1:0] CAP = 8'h7F;

    logic clk = 1'b0, rst = 1'b1, sleep_req = 1'b0, gie = 1'b0;
    logic wdt_timeout = 1'b0, ext_reset = 1'b0;
    logic [N-1:0] irq_flag = '0, irq_en = '0;
    logic core_clk_en, osc_en, wdt_clr, pd_n, to_n, wake_done, vec_next, dev_rst;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    slp_wake_ctrl #(.N(N), .CAP_MASK(CAP), .SYNC_STAGES(SYNC), .OSC_READY(RDY)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .irq_flag(irq_flag), .irq_en(irq_en),
        .gie(gie), .wdt_timeout(wdt_timeout), .ext_reset(ext_reset),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .wdt_clr(wdt_clr), .pd_n(pd_n),
        .to_n(to_n), .wake_done(wake_done), .vec_next(vec_next), .dev_rst(dev_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_wake(logic [N-1:0] f, logic [N-1:0] e);
        return |(f & e & CAP);
    endfunction

    function automatic bit exp_pending(logic [N-1:0] f, logic [N-1:0] e);
        return |(f & e);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        irq_flag = '0;
        irq_en   = '0;
        repeat (4) step();
    endtask

    task automatic enter_sleep();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R2", "clk_en", core_clk_en, 0);
        chk("R2", "osc_en", osc_en, 0);
        chk("R2", "pd_n", pd_n, 0);
        chk("R2", "to_n", to_n, 1);
        chk("R2", "wdt_clr", wdt_clr, 1);
        step();
        chk("R2", "wdt_clr one cycle", wdt_clr, 0);
    endtask

    task automatic check_release(input string req, input bit g, input bit exp_to);
        chk(req, "wake_done", wake_done, 1);
        chk("R6", "wdt_clr at release", wdt_clr, 1);
        chk("R6", "vec_next", vec_next, g);
        chk("R6", "pd_n", pd_n, 0);
        chk(req, "to_n", to_n, exp_to);
        step();
        chk("R6", "wake_done one cycle", wake_done, 0);
    endtask

    task automatic wake_irq(input logic [N-1:0] f, input logic [N-1:0] e, input bit g);
        int n = 0, nosc = 0;
        irq_flag = f; irq_en = e; gie = g;
        for (int i = 0; i < 40; i++) begin
            step();
            n++;
            if (osc_en && nosc == 0) nosc = n;
            if (core_clk_en) break;
        end
        chk("R4", "osc latency", nosc, SYNC + 1);
        chk("R4", "clk latency", n, SYNC + RDY + 1);
        check_release("R3", g, 1);
        quiet();
    endtask

    task automatic wake_wdt(input bit g);
        int n = 0;
        gie = g;
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        n = 1;
        chk("R5", "osc_en", osc_en, 1);
        chk("R5", "to_n", to_n, 0);
        chk("R5", "clk_en still off", core_clk_en, 0);
        for (int i = 0; i < 40 && !core_clk_en; i++) begin
            step();
            n++;
        end
        chk("R5", "clk latency", n, RDY + 1);
        check_release("R5", g, 0);
        quiet();
    endtask

    task automatic no_wake(input logic [N-1:0] f, input logic [N-1:0] e, input bit g);
        irq_flag = f; irq_en = e; gie = g;
        repeat (SYNC + RDY + 4) step();
        chk("R3", "clk_en stays off", core_clk_en, 0);
        chk("R3", "osc_en stays off", osc_en, 0);
        irq_flag = '0; irq_en = '0;
        repeat (3) step();
        wake_wdt(g);
    endtask

    task automatic immediate(input logic [N-1:0] f, input logic [N-1:0] e, input bit g);
        irq_flag = f; irq_en = e; gie = g;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R7", "clk_en", core_clk_en, 1);
        chk("R7", "osc_en", osc_en, 1);
        chk("R7", "pd_n", pd_n, 0);
        chk("R7", "to_n", to_n, 1);
        chk("R7", "wdt_clr", wdt_clr, 1);
        chk("R7", "wake_done", wake_done, 1);
        chk("R7", "vec_next", vec_next, g);
        quiet();
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1", "clk_en", core_clk_en, 1);
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "pd_n", pd_n, 1);
        chk("R1", "to_n", to_n, 1);
        chk("R1", "wdt_clr", wdt_clr, 0);
        chk("R1", "wake_done", wake_done, 0);
        chk("R1", "vec_next", vec_next, 0);
        chk("R1", "dev_rst", dev_rst, 0);

        // directed: qualifying wake with gie clear and set
        enter_sleep(); wake_irq(8'h01, 8'h01, 1'b0);
        enter_sleep(); wake_irq(8'h40, 8'hC0, 1'b1);
        // directed: incapable source (bit 7) and missing enable
        enter_sleep(); no_wake(8'h80, 8'h80, 1'b1);
        enter_sleep(); no_wake(8'h3C, 8'hC3, 1'b0);
        // directed: incapable source pending still forces immediate wake
        immediate(8'h80, 8'h80, 1'b1);
        immediate(8'h05, 8'h04, 1'b0);

        // R9: strobe while asleep is ignored
        enter_sleep();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk("R9", "clk_en", core_clk_en, 0);
        chk("R9", "wdt_clr", wdt_clr, 0);
        chk("R9", "pd_n", pd_n, 0);
        chk("R9", "to_n", to_n, 1);
        step();
        wake_wdt(1'b1);

        // R8: external reset while asleep, after a watchdog wake left to_n=0
        enter_sleep();
        wake_wdt(1'b0);
        enter_sleep();
        wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
        chk("R8", "to_n before", to_n, 0);
        ext_reset = 1'b1; step(); ext_reset = 1'b0;
        chk("R8", "dev_rst", dev_rst, 1);
        chk("R8", "clk_en", core_clk_en, 1);
        chk("R8", "osc_en", osc_en, 1);
        chk("R8", "wake_done", wake_done, 0);
        chk("R8", "wdt_clr", wdt_clr, 0);
        chk("R8", "pd_n held", pd_n, 0);
        chk("R8", "to_n held", to_n, 0);
        step();
        chk("R8", "dev_rst released", dev_rst, 0);
        quiet();

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] f, e;
            bit g;
            int kind;
            f = N'($urandom);
            e = N'($urandom);
            g = 1'($urandom);
            kind = int'($urandom % 4);
            if (kind == 0) begin
                if (exp_pending(f, e)) immediate(f, e, g);
            end else if (kind == 1) begin
                enter_sleep();
                wake_wdt(g);
            end else begin
                enter_sleep();
                if (exp_wake(f, e)) wake_irq(f, e, g);
                else                no_wake(f, e, g);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule